// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block holds the digital side of an integer-N frequency synthesizer. A 15-bit programmable counter divides the prescaled RF clock. A second counter divides the crystal clock by one of three fixed ratios. The two divided pulse trains drive a phase-frequency detector, which raises up and down correction pulses.

A lock monitor watches the width of those pulses and maintains a lock flag, which is presented active low. A small register bank sets the charge-pump current code, the tuning-amplifier enable and four band-switch drives. The current code has an automatic mode that drops to low current while the loop is locked.

The whole core runs on the crystal clock `clk`. The prescaled RF clock enters as `rf_tick`, a synchronous one-cycle enable for each RF edge. A separate serial front end writes the registers through three one-cycle load strobes with parallel data.

Top module: `pll_synth_core`

## Requirements
- R1: While `rst` is high, every output is in its reset state: `lock_n`=1, `acps`=1, `cp_high`=1, `tune_en`=0, `band_on`=0000, `pfd_up`=`pfd_dn`=0.
- R2: `main_pulse` is high for one cycle every N `rf_tick` cycles, where N is the last `div_in` loaded (unsigned, bit 14 most significant). N of 0 or 1 gives a pulse on every tick. A load of `ld_div` restarts this count.
- R3: `ref_pulse` is high for one cycle every R `clk` cycles. R is chosen by `ctrl_in[2:1]`: 00 selects 512, 01 selects 640, and 10 or 11 selects 1024. The reset selection is 00. A load of `ld_ctrl` restarts this count.
- R4: A `ref_pulse` sets `pfd_up` and a `main_pulse` sets `pfd_dn`. When both are high, both clear on the next cycle. Any divider load also clears both. An offset of d cycles, with the reference leading, gives an up pulse d+1 cycles wide and a down pulse 1 cycle wide.
- R5: `lock_n` goes low after 8 consecutive comparisons whose phase error is under 2 clock cycles. An error of exactly 2 cycles never locks.
- R6: Once locked, the first comparison whose error reaches 2 cycles drives `lock_n` high again.
- R7: `cp_high` follows `ctrl_in[6]`: 1 selects the high current code and 0 selects the low one. The reset value is 1.
- R8: When `ctrl_in[5:3]` equals 001 and the loop is locked, `cp_high` and `acps` are both 0. In every other case `acps` is 1.
- R9: `band_on[n]` is the inverse of `band_in[n]` after an `ld_band` load. Loads of the other registers leave it unchanged.
- R10: `tune_en` is the inverse of `ctrl_in[0]`, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_tick | input | 1 | One-cycle enable per prescaled RF edge |
| ld_div | input | 1 | Load strobe for the main ratio |
| div_in | input | 15 | Main divide ratio N |
| ld_ctrl | input | 1 | Load strobe for the control word |
| ctrl_in | input | 7 | {current select, test code[2:0], reference select[1:0], tuning disable} |
| ld_band | input | 1 | Load strobe for the band bits |
| band_in | input | 4 | Band bits, 0 = switch on |
| ref_pulse | output | 1 | Divided reference pulse |
| main_pulse | output | 1 | Divided RF pulse |
| pfd_up | output | 1 | Detector up pulse |
| pfd_dn | output | 1 | Detector down pulse |
| lock_n | output | 1 | Lock flag, active low |
| acps | output | 1 | 0 while automatic low current is in force |
| cp_high | output | 1 | Charge-pump current code, 1 = high |
| tune_en | output | 1 | Tuning amplifier enable |
| band_on | output | 4 | Band-switch drives, 1 = on |

## Verification
Each divider's count check assumes that its ratio changes only in the same cycle as that divider's restart. The top level ties these together, so the bench only changes ratios through the load strobes. The band-hold property assumes the load strobes stay low through reset. The bench holds every strobe low except for a single cycle per load, and drives each strobe half a period away from the active edge. Lock scenarios always begin from a reset followed by a joint divider and control load. Phase offsets come only from whole-cycle gaps in `rf_tick`, so each offset is an exact integer count of clock cycles.

// File: rtl/pll_synth_pkg.sv
`timescale 1ns/1ps
package pll_synth_pkg;
  typedef struct packed {
    logic       cp_hi;   // current select
    logic [2:0] test;    // test code
    logic [1:0] rsel;    // reference ratio select
    logic       os;      // 1 = tuning amplifier off
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);

  localparam ctrl_word_t CTRL_RESET = '{cp_hi: 1'b1, test: 3'b000, rsel: 2'b00, os: 1'b1};
endpackage

// File: rtl/prog_divider.sv
`timescale 1ns/1ps
module prog_divider #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W:0]   cnt_nx;
  logic         at_end;

  assign cnt_nx = {1'b0, cnt} + (W+1)'(1);
  assign at_end = cnt_nx >= {1'b0, ratio};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (at_end) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt_nx[W-1:0];
        end
      end
    end
  end

  // R2 / R3: the count never passes the programmed ratio
  a_r2_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (ratio >= W'(2)) |-> (cnt < ratio));

  // R2 / R3: a restart leaves the output quiet on the next cycle
  a_r2_r3_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !pulse);
endmodule

// File: rtl/pfd_dff.sv
`timescale 1ns/1ps
module pfd_dff (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_p,
  input  logic fb_p,
  output logic up,
  output logic dn
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | ref_p;
      dn <= dn | fb_p;
    end
  end

  // R4: both flip-flops set means both clear one cycle later
  a_r4_both_clear: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!up && !dn));

  // R4: an up pulse only starts from a reference pulse
  a_r4_up_from_ref: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(ref_p));
endmodule

// File: rtl/lock_monitor.sv
`timescale 1ns/1ps
module lock_monitor #(
  parameter int LOCK_CYC = 8,
  parameter int ERR_LIM  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int GW = $clog2(LOCK_CYC + 1);
  localparam int EW = $clog2(ERR_LIM + 2);
  localparam logic [EW-1:0] ERR_MAX   = EW'(ERR_LIM);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_CYC - 1);

  logic [EW-1:0] err_q;
  logic [GW-1:0] good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else if (clr) begin
      err_q <= '0;
    end else if (up && dn) begin
      err_q <= '0;
      if (err_q < ERR_MAX) begin
        if (good_q == GOOD_LAST) locked <= 1'b1;
        else                     good_q <= good_q + GW'(1);
      end else begin
        good_q <= '0;
      end
    end else if (up ^ dn) begin
      if (err_q + EW'(1) >= ERR_MAX) begin
        err_q  <= ERR_MAX;
        good_q <= '0;
        locked <= 1'b0;
      end else begin
        err_q <= err_q + EW'(1);
      end
    end
  end

  // R6: an error at the limit is never seen together with lock
  a_r6_err_unlocks: assert property (@(posedge clk) disable iff (rst)
    (err_q == ERR_MAX) |-> !locked);

  // R5: lock is only gained at the close of a comparison
  a_r5_rise_on_compare: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(up && dn));
endmodule

// File: rtl/synth_regs.sv
`timescale 1ns/1ps
module synth_regs
  import pll_synth_pkg::*;
#(
  parameter int         DIV_W     = 15,
  parameter int         BANDS     = 4,
  parameter logic [2:0] AUTO_CODE = 3'b001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_div,
  input  logic [DIV_W-1:0] div_in,
  input  logic             ld_ctrl,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic             ld_band,
  input  logic [BANDS-1:0] band_in,
  input  logic             locked,
  output logic [DIV_W-1:0] div_q,
  output logic [1:0]       rsel,
  output logic             cp_high_q,
  output logic             acps_q,
  output logic             tune_en_q,
  output logic [BANDS-1:0] band_on_q
);
  ctrl_word_t ctrl_q;
  logic       low_forced;

  assign low_forced = (ctrl_q.test == AUTO_CODE) && locked;
  assign rsel       = ctrl_q.rsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      ctrl_q    <= CTRL_RESET;
      band_on_q <= '0;
      cp_high_q <= 1'b1;
      acps_q    <= 1'b1;
      tune_en_q <= 1'b0;
    end else begin
      if (ld_div)  div_q     <= div_in;
      if (ld_ctrl) ctrl_q    <= ctrl_word_t'(ctrl_in);
      if (ld_band) band_on_q <= ~band_in;
      cp_high_q <= ctrl_q.cp_hi & ~low_forced;
      acps_q    <= ~low_forced;
      tune_en_q <= ~ctrl_q.os;
    end
  end

  // R8: the flag low always comes with the low current code
  a_r8_acps_low_current: assert property (@(posedge clk) disable iff (rst)
    !acps_q |-> !cp_high_q);

  // R9: band drives move only after a band load
  a_r9_band_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_band) |-> $stable(band_on_q));
endmodule

// File: rtl/pll_synth_core.sv
`timescale 1ns/1ps
module pll_synth_core
  import pll_synth_pkg::*;
#(
  parameter int         DIV_W     = 15,
  parameter int         REF_A     = 512,
  parameter int         REF_B     = 640,
  parameter int         REF_C     = 1024,
  parameter int         LOCK_CYC  = 8,
  parameter int         ERR_LIM   = 2,
  parameter int         BANDS     = 4,
  parameter logic [2:0] AUTO_CODE = 3'b001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_tick,
  input  logic              ld_div,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              ld_ctrl,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              ld_band,
  input  logic [BANDS-1:0]  band_in,
  output logic              ref_pulse,
  output logic              main_pulse,
  output logic              pfd_up,
  output logic              pfd_dn,
  output logic              lock_n,
  output logic              acps,
  output logic              cp_high,
  output logic              tune_en,
  output logic [BANDS-1:0]  band_on
);
  localparam int REF_W = $clog2(REF_C + 1);

  logic [DIV_W-1:0] div_q;
  logic [1:0]       rsel;
  logic [REF_W-1:0] ref_ratio;
  logic             locked;
  logic             cmp_clr;

  assign cmp_clr = ld_div | ld_ctrl;

  always_comb begin
    case (rsel)
      2'b00:   ref_ratio = REF_W'(REF_A);
      2'b01:   ref_ratio = REF_W'(REF_B);
      default: ref_ratio = REF_W'(REF_C);
    endcase
  end

  synth_regs #(.DIV_W(DIV_W), .BANDS(BANDS), .AUTO_CODE(AUTO_CODE)) u_regs (
    .clk(clk), .rst(rst),
    .ld_div(ld_div), .div_in(div_in),
    .ld_ctrl(ld_ctrl), .ctrl_in(ctrl_in),
    .ld_band(ld_band), .band_in(band_in),
    .locked(locked),
    .div_q(div_q), .rsel(rsel),
    .cp_high_q(cp_high), .acps_q(acps),
    .tune_en_q(tune_en), .band_on_q(band_on)
  );

  prog_divider #(.W(DIV_W)) u_main_div (
    .clk(clk), .rst(rst), .restart(ld_div), .tick(rf_tick),
    .ratio(div_q), .pulse(main_pulse)
  );

  prog_divider #(.W(REF_W)) u_ref_div (
    .clk(clk), .rst(rst), .restart(ld_ctrl), .tick(1'b1),
    .ratio(ref_ratio), .pulse(ref_pulse)
  );

  pfd_dff u_pfd (
    .clk(clk), .rst(rst), .clr(cmp_clr),
    .ref_p(ref_pulse), .fb_p(main_pulse),
    .up(pfd_up), .dn(pfd_dn)
  );

  lock_monitor #(.LOCK_CYC(LOCK_CYC), .ERR_LIM(ERR_LIM)) u_lock (
    .clk(clk), .rst(rst), .clr(cmp_clr),
    .up(pfd_up), .dn(pfd_dn), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_n <= 1'b1;
    else     lock_n <= ~locked;
  end

  // R5 / R6: the pin flag tracks the internal lock one cycle late
  a_r5_r6_flag_follows: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> !lock_n);
endmodule

// File: tb/pll_synth_core_tb.sv
`timescale 1ns/1ps
module pll_synth_core_tb;
  import pll_synth_pkg::*;

  localparam int DIV_W = 15;
  localparam int BANDS = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rf_tick = 1'b0;
  logic              ld_div = 1'b0, ld_ctrl = 1'b0, ld_band = 1'b0;
  logic [DIV_W-1:0]  div_in = '0;
  logic [CTRL_W-1:0] ctrl_in = '0;
  logic [BANDS-1:0]  band_in = '0;
  logic              ref_pulse, main_pulse, pfd_up, pfd_dn;
  logic              lock_n, acps, cp_high, tune_en;
  logic [BANDS-1:0]  band_on;

  pll_synth_core u_dut (
    .clk(clk), .rst(rst), .rf_tick(rf_tick),
    .ld_div(ld_div), .div_in(div_in),
    .ld_ctrl(ld_ctrl), .ctrl_in(ctrl_in),
    .ld_band(ld_band), .band_in(band_in),
    .ref_pulse(ref_pulse), .main_pulse(main_pulse),
    .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .lock_n(lock_n), .acps(acps), .cp_high(cp_high),
    .tune_en(tune_en), .band_on(band_on)
  );

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int rf_skip = 0, rf_mode = 0;

  string tag_q[$];
  int    sel_q[$];
  int    exp_q[$];

  int ref_cnt = 0, ref_period = 0, main_cnt = 0, main_period = 0;
  int up_cnt = 0, up_width = 0, dn_cnt = 0, dn_width = 0;

  localparam int S_LOCKN = 0, S_ACPS = 1, S_CPH = 2, S_TUNE = 3, S_BAND = 4;
  localparam int S_REFP = 5, S_MAINP = 6, S_UPW = 7, S_DNW = 8, S_PFD = 9;

  function automatic int actual(int sel);
    case (sel)
      S_LOCKN: return int'(lock_n);
      S_ACPS:  return int'(acps);
      S_CPH:   return int'(cp_high);
      S_TUNE:  return int'(tune_en);
      S_BAND:  return int'(band_on);
      S_REFP:  return ref_period;
      S_MAINP: return main_period;
      S_UPW:   return up_width;
      S_DNW:   return dn_width;
      default: return int'({pfd_up, pfd_dn});
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] cw(bit cp, logic [2:0] t, logic [1:0] rs, bit os);
    return {cp, t, rs, os};
  endfunction

  // driver side of the scoreboard
  task automatic expect_val(int sel, int exp, string tag);
    tag_q.push_back(tag);
    sel_q.push_back(sel);
    exp_q.push_back(exp);
  endtask

  task automatic drain();
    while (sel_q.size() != 0) @(posedge clk);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(bit dd, int n, bit dc, logic [CTRL_W-1:0] c, bit db,
                      logic [BANDS-1:0] b, int skip);
    @(negedge clk);
    ld_div  = dd;  div_in  = DIV_W'(n);
    ld_ctrl = dc;  ctrl_in = c;
    ld_band = db;  band_in = b;
    if (skip > 0) rf_skip = skip;
    @(negedge clk);
    ld_div = 1'b0; ld_ctrl = 1'b0; ld_band = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rf_mode = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // RF tick source: continuous, alternating, or with a gap
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rf_skip > 0) begin
        rf_tick = 1'b0;
        rf_skip--;
      end else if (rf_mode == 1) begin
        rf_tick = ~rf_tick;
      end else begin
        rf_tick = 1'b1;
      end
    end
  end

  // monitor: measures pulse spacing and widths, then pops and compares
  initial begin
    forever begin
      @(negedge clk);
      ref_cnt++;
      if (ref_pulse) begin ref_period = ref_cnt; ref_cnt = 0; end
      main_cnt++;
      if (main_pulse) begin main_period = main_cnt; main_cnt = 0; end
      if (pfd_up) up_cnt++;
      else if (up_cnt > 0) begin up_width = up_cnt; up_cnt = 0; end
      if (pfd_dn) dn_cnt++;
      else if (dn_cnt > 0) begin dn_width = dn_cnt; dn_cnt = 0; end
      if (sel_q.size() > 0) begin
        automatic string t = tag_q.pop_front();
        automatic int    s = sel_q.pop_front();
        automatic int    e = exp_q.pop_front();
        automatic int    a = actual(s);
        compared++;
        if (a !== e) begin
          mismatched++;
          $display("FAIL %s: actual %0d expected %0d", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    expect_val(S_LOCKN, 1, "R1 lock_n");
    expect_val(S_ACPS,  1, "R1 acps");
    expect_val(S_CPH,   1, "R1 cp_high");
    expect_val(S_TUNE,  0, "R1 tune_en");
    expect_val(S_BAND,  0, "R1 band_on");
    expect_val(S_PFD,   0, "R1 pfd");
    drain();
    rst = 1'b0;

    // R3 default ratio, R2 ratio zero
    cycles(1100);
    expect_val(S_REFP,  512, "R3 ref 512 default");
    expect_val(S_MAINP, 1,   "R2 N=0 every tick");
    drain();
    load(0, 0, 1, cw(1, 3'b000, 2'b01, 1), 0, '0, 0);
    cycles(1400);
    expect_val(S_REFP, 640, "R3 ref 640");
    drain();
    load(0, 0, 1, cw(1, 3'b000, 2'b10, 1), 0, '0, 0);
    cycles(2200);
    expect_val(S_REFP, 1024, "R3 ref 1024 code 10");
    drain();
    load(0, 0, 1, cw(1, 3'b000, 2'b11, 1), 0, '0, 0);
    cycles(2200);
    expect_val(S_REFP, 1024, "R3 ref 1024 code 11");
    drain();

    // R2 main divider
    load(1, 100, 0, '0, 0, '0, 0);
    cycles(250);
    expect_val(S_MAINP, 100, "R2 N=100");
    drain();
    load(1, 1, 0, '0, 0, '0, 0);
    cycles(10);
    expect_val(S_MAINP, 1, "R2 N=1");
    drain();
    rf_mode = 1;
    load(1, 300, 0, '0, 0, '0, 0);
    cycles(1300);
    expect_val(S_MAINP, 600, "R2 N=300 half-rate ticks");
    drain();
    rf_mode = 0;

    // R7, R10, R9 register effects
    load(0, 0, 1, cw(0, 3'b000, 2'b00, 1), 0, '0, 0);
    cycles(5);
    expect_val(S_CPH,  0, "R7 low current");
    expect_val(S_TUNE, 0, "R10 tuning off");
    drain();
    load(0, 0, 1, cw(1, 3'b000, 2'b00, 0), 0, '0, 0);
    cycles(5);
    expect_val(S_CPH,  1, "R7 high current");
    expect_val(S_TUNE, 1, "R10 tuning on");
    drain();
    load(0, 0, 0, '0, 1, 4'b0101, 0);
    cycles(3);
    expect_val(S_BAND, 4'b1010, "R9 band 0101");
    drain();
    load(0, 0, 1, cw(1, 3'b000, 2'b00, 1), 0, 4'b1111, 0);
    cycles(5);
    expect_val(S_BAND, 4'b1010, "R9 band unchanged by ctrl load");
    expect_val(S_TUNE, 0,       "R10 tuning off again");
    drain();
    load(0, 0, 0, '0, 1, 4'b0000, 0);
    cycles(3);
    expect_val(S_BAND, 4'b1111, "R9 band 0000");
    drain();

    // R5 / R8 / R4 aligned lock with automatic current
    do_reset();
    load(1, 512, 1, cw(1, 3'b001, 2'b00, 0), 0, '0, 1);
    cycles(7 * 512 + 200);
    expect_val(S_LOCKN, 1, "R5 not locked after 7");
    expect_val(S_ACPS,  1, "R8 acps high before lock");
    expect_val(S_CPH,   1, "R8 high current before lock");
    drain();
    cycles(512);
    expect_val(S_LOCKN, 0, "R5 locked after 8");
    expect_val(S_ACPS,  0, "R8 acps low when locked");
    expect_val(S_CPH,   0, "R8 forced low current");
    expect_val(S_UPW,   1, "R4 up width aligned");
    expect_val(S_DNW,   1, "R4 dn width aligned");
    drain();
    rf_skip = 2;
    cycles(1100);
    expect_val(S_LOCKN, 1, "R6 lock lost at error 2");
    expect_val(S_ACPS,  1, "R8 acps back high");
    expect_val(S_CPH,   1, "R8 current restored");
    drain();

    // R5 / R4 one-cycle offset still locks
    do_reset();
    load(1, 512, 1, cw(1, 3'b000, 2'b00, 0), 0, '0, 2);
    cycles(9 * 512);
    expect_val(S_LOCKN, 0, "R5 locked at error 1");
    expect_val(S_ACPS,  1, "R8 acps high without auto");
    expect_val(S_CPH,   1, "R7 high current kept");
    expect_val(S_UPW,   2, "R4 up width offset 1");
    expect_val(S_DNW,   1, "R4 dn width offset 1");
    drain();

    // R5 / R4 two-cycle offset never locks
    do_reset();
    load(1, 512, 1, cw(1, 3'b000, 2'b00, 0), 0, '0, 3);
    cycles(12 * 512);
    expect_val(S_LOCKN, 1, "R5 no lock at error 2");
    expect_val(S_UPW,   3, "R4 up width offset 2");
    expect_val(S_DNW,   1, "R4 dn width offset 2");
    drain();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule